// File: doc/BRIEF.md
# Clock-Generator Configuration Slave (SMBus block transfers)

This block is a two-wire serial slave that holds the byte-wide configuration bank of a clock generator. A host writes the bank with a single block-write transaction: the slave address, a command byte, a byte-count byte, then data bytes. The command and count bytes must be sent but are discarded. The data bytes fill the bank in ascending order from register 0. The host may stop after any whole byte, and any register not reached keeps its value. The slave supports no byte or word protocols.

Two pairs of registers set divider ratios and spread amount. Each pair must change as one unit. A pair's bytes are collected in shadow storage and reach the live bank at the STOP only if both bytes arrived in that transaction. One register sets how many bytes a block read returns. It cannot be set to zero. A block read returns that count first, then the registers from 0 upward. The live bank is presented in parallel to the clock logic.

The serial lines pass through a short synchroniser into the system clock domain. The data line is open-drain and is modelled as an input, an output that is always low, and an output enable.

Top module: `clkcfg_smbus_slave`

## Requirements
- R1: The slave ACKs an address byte whose upper seven bits equal `SLAVE_ADDR` (default 0x69), for either value of the LSB (0 = write, 1 = read). For any other address it gives no ACK and leaves SDA released until the next START.
- R2: In a write, the two bytes after the address (command, count) are ACKed and discarded. Data byte k is ACKed and stored into register k (k = 0, 1, 2, ...). Register k appears on `cfg_o[8k+7:8k]`.
- R3: Registers past the last complete data byte keep their values. A data byte cut short by STOP stores nothing.
- R4: Register `CNT_IDX` (8) resets to 0x08. A write of 0x00 to it is ignored and the old value is kept.
- R5: Registers 11/12 form one pair and 13/14 form another. Each pair is copied to the live bank at STOP only when both of its bytes were received in the same transaction. Otherwise both bytes of the pair keep their values.
- R6: Register `ID_IDX` (7) reads {4'b1001, `REV`}. Writes to it have no effect.
- R7: After reset, register 8 holds 0x08, register 7 holds the identification byte, and every other register holds 0x00.
- R8: In a read, the slave sends register 8's value first, then registers 0, 1, ... while fewer than that count have been sent. Any later byte reads 0xFF.
- R9: When the host NACKs a read byte, the slave releases SDA. A following transaction is served normally.
- R10: `sda_oe` changes only while SCL is low, and `sda_o` is always 0.
- R11: Data bytes beyond register `NUM_REGS-1` are ACKed and discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, as seen on the pad |
| sda_i | input | 1 | Serial data line, as seen on the pad |
| sda_o | output | 1 | Data value driven when enabled; always 0 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| cfg_o | output | NUM_REGS*8 | Live register bank, register k at bits [8k+7:8k] |

## Verification
The bench uses the default geometry: 21 registers, two synchroniser stages and pairs at 11–14. It overrides `REV` to 5, so the identification byte is 0x95 and cannot be mistaken for the zeros in the other registers. With 21 registers, a 23-byte block reaches the end of the bank, where trailing bytes must be ACKed and dropped. Transactions of 12 and 14 data bytes each end in the middle of a pair, so each pair is tested both committed and left uncommitted. A quarter SCL phase of ten system clocks leaves room for the three-cycle synchroniser delay, so every output-enable change can be seen to fall inside the SCL-low window.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] ID_NIBBLE = 4'b1001;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_WR_BYTE,
        LK_WR_ACK,
        LK_RD_BYTE,
        LK_RD_ACK
    } link_st_e;
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        sy_d.scl_pipe[0] = scl_i;
        sy_d.sda_pipe[0] = sda_i;
        for (int i = 1; i < STAGES; i++) begin
            sy_d.scl_pipe[i] = sy_q.scl_pipe[i-1];
            sy_d.sda_pipe[i] = sy_q.sda_pipe[i-1];
        end
        sy_d.scl_prev = sy_q.scl_pipe[STAGES-1];
        sy_d.sda_prev = sy_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '1;
        else        sy_q <= sy_d;
    end

    assign scl_s_o    = sy_q.scl_pipe[STAGES-1];
    assign sda_s_o    = sy_q.sda_pipe[STAGES-1];
    assign scl_rise_o = scl_s_o & ~sy_q.scl_prev;
    assign scl_fall_o = ~scl_s_o & sy_q.scl_prev;
    assign start_o    = scl_s_o & sy_q.scl_prev & sy_q.sda_prev & ~sda_s_o;
    assign stop_o     = scl_s_o & sy_q.scl_prev & ~sy_q.sda_prev & sda_s_o;
endmodule

// File: rtl/cfgs_link.sv
module cfgs_link
    import cfgs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         BC_W       = 6,
    parameter int         RP_W       = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_s_i,
    input  logic            sda_s_i,
    input  logic            scl_rise_i,
    input  logic            scl_fall_i,
    input  logic            start_i,
    input  logic            stop_i,
    input  byte_t           rd_data_i,
    output logic            sda_oe_o,
    output logic [RP_W-1:0] rd_ptr_o,
    output logic            wr_stb_o,
    output logic [BC_W-1:0] wr_idx_o,
    output byte_t           wr_data_o
);
    typedef struct packed {
        link_st_e        st;
        logic [3:0]      bit_cnt;
        byte_t           shreg;
        logic            rw;
        logic [BC_W-1:0] byte_cnt;
        logic [RP_W-1:0] rd_ptr;
        byte_t           tx;
        logic            oe;
        logic            macked;
        logic            wr_stb;
        byte_t           wr_data;
        logic [BC_W-1:0] wr_idx;
    } link_t;

    link_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        lk_d.wr_stb = 1'b0;
        if (start_i) begin
            lk_d.st       = LK_ADDR;
            lk_d.bit_cnt  = '0;
            lk_d.oe       = 1'b0;
            lk_d.byte_cnt = '0;
            lk_d.rd_ptr   = '0;
        end else if (stop_i) begin
            lk_d.st = LK_IDLE;
            lk_d.oe = 1'b0;
        end else begin
            unique case (lk_q.st)
                LK_ADDR: begin
                    if (scl_rise_i) begin
                        lk_d.shreg   = {lk_q.shreg[6:0], sda_s_i};
                        lk_d.bit_cnt = lk_q.bit_cnt + 4'd1;
                    end else if (scl_fall_i && lk_q.bit_cnt == 4'd8) begin
                        if (lk_q.shreg[7:1] == SLAVE_ADDR) begin
                            lk_d.st = LK_ADDR_ACK;
                            lk_d.oe = 1'b1;
                            lk_d.rw = lk_q.shreg[0];
                        end else begin
                            lk_d.st = LK_IDLE;
                        end
                    end
                end
                LK_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        lk_d.bit_cnt = '0;
                        if (lk_q.rw) begin
                            lk_d.st = LK_RD_BYTE;
                            lk_d.tx = rd_data_i;
                            lk_d.oe = ~rd_data_i[7];
                        end else begin
                            lk_d.st = LK_WR_BYTE;
                            lk_d.oe = 1'b0;
                        end
                    end
                end
                LK_WR_BYTE: begin
                    if (scl_rise_i) begin
                        lk_d.shreg   = {lk_q.shreg[6:0], sda_s_i};
                        lk_d.bit_cnt = lk_q.bit_cnt + 4'd1;
                    end else if (scl_fall_i && lk_q.bit_cnt == 4'd8) begin
                        lk_d.st = LK_WR_ACK;
                        lk_d.oe = 1'b1;
                        if (lk_q.byte_cnt >= BC_W'(2)) begin
                            lk_d.wr_stb  = 1'b1;
                            lk_d.wr_data = lk_q.shreg;
                            lk_d.wr_idx  = lk_q.byte_cnt - BC_W'(2);
                        end
                        if (lk_q.byte_cnt != '1) lk_d.byte_cnt = lk_q.byte_cnt + BC_W'(1);
                    end
                end
                LK_WR_ACK: begin
                    if (scl_fall_i) begin
                        lk_d.st      = LK_WR_BYTE;
                        lk_d.oe      = 1'b0;
                        lk_d.bit_cnt = '0;
                    end
                end
                LK_RD_BYTE: begin
                    if (scl_fall_i) begin
                        if (lk_q.bit_cnt == 4'd7) begin
                            lk_d.st = LK_RD_ACK;
                            lk_d.oe = 1'b0;
                        end else begin
                            lk_d.tx      = {lk_q.tx[6:0], 1'b0};
                            lk_d.oe      = ~lk_q.tx[6];
                            lk_d.bit_cnt = lk_q.bit_cnt + 4'd1;
                        end
                    end
                end
                LK_RD_ACK: begin
                    if (scl_rise_i) begin
                        lk_d.macked = ~sda_s_i;
                        if (!sda_s_i && lk_q.rd_ptr != '1) lk_d.rd_ptr = lk_q.rd_ptr + RP_W'(1);
                    end else if (scl_fall_i) begin
                        if (lk_q.macked) begin
                            lk_d.st      = LK_RD_BYTE;
                            lk_d.bit_cnt = '0;
                            lk_d.tx      = rd_data_i;
                            lk_d.oe      = ~rd_data_i[7];
                        end else begin
                            lk_d.st = LK_IDLE;
                        end
                    end
                end
                default: lk_d.st = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: LK_IDLE, default: '0};
        else        lk_q <= lk_d;
    end

    assign sda_oe_o  = lk_q.oe;
    assign rd_ptr_o  = lk_q.rd_ptr;
    assign wr_stb_o  = lk_q.wr_stb;
    assign wr_idx_o  = lk_q.wr_idx;
    assign wr_data_o = lk_q.wr_data;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s_i); // R10

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_q.st == LK_RD_ACK && scl_fall_i && !lk_q.macked && !start_i && !stop_i)
        |=> (!sda_oe_o && lk_q.st == LK_IDLE)); // R9

    AST_WR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> sda_oe_o); // R2
endmodule

// File: rtl/cfgs_regbank.sv
module cfgs_regbank
    import cfgs_pkg::*;
#(
    parameter int         NUM_REGS   = 21,
    parameter int         BC_W       = 6,
    parameter int         RP_W       = 9,
    parameter int         CNT_IDX    = 8,
    parameter int         ID_IDX     = 7,
    parameter int         PAIR_FIRST = 11,
    parameter int         NUM_PAIRS  = 2,
    parameter logic [3:0] REV        = 4'h1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb_i,
    input  logic [BC_W-1:0]            wr_idx_i,
    input  byte_t                      wr_data_i,
    input  logic                       start_i,
    input  logic                       stop_i,
    input  logic [RP_W-1:0]            rd_ptr_i,
    output byte_t                      rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int PAIR_END = PAIR_FIRST + 2 * NUM_PAIRS;

    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0]    regs;
        logic [2*NUM_PAIRS-1:0][BYTE_W-1:0] shadow;
        logic [2*NUM_PAIRS-1:0]             sh_vld;
    } bank_t;

    bank_t bk_d, bk_q;

    function automatic bank_t bank_reset();
        bank_t b;
        b = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i == CNT_IDX)     b.regs[i] = 8'h08;
            else if (i == ID_IDX) b.regs[i] = {ID_NIBBLE, REV};
        end
        return b;
    endfunction

    always_comb begin
        int idx;
        bk_d = bk_q;
        idx  = int'(wr_idx_i);
        if (wr_stb_i && wr_idx_i < BC_W'(NUM_REGS)) begin
            if (idx >= PAIR_FIRST && idx < PAIR_END) begin
                bk_d.shadow[idx-PAIR_FIRST] = wr_data_i;
                bk_d.sh_vld[idx-PAIR_FIRST] = 1'b1;
            end else if (idx == CNT_IDX) begin
                if (wr_data_i != 8'h00) bk_d.regs[idx] = wr_data_i;
            end else if (idx != ID_IDX) begin
                bk_d.regs[idx] = wr_data_i;
            end
        end
        if (stop_i) begin
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (bk_q.sh_vld[2*p] && bk_q.sh_vld[2*p+1]) begin
                    bk_d.regs[PAIR_FIRST+2*p]   = bk_q.shadow[2*p];
                    bk_d.regs[PAIR_FIRST+2*p+1] = bk_q.shadow[2*p+1];
                end
            end
            bk_d.sh_vld = '0;
        end
        if (start_i) bk_d.sh_vld = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= bank_reset();
        else        bk_q <= bk_d;
    end

    always_comb begin
        logic [RP_W-1:0] pos;
        pos = rd_ptr_i - RP_W'(1);
        if (rd_ptr_i == '0) begin
            rd_data_o = bk_q.regs[CNT_IDX];
        end else if (pos < RP_W'(bk_q.regs[CNT_IDX]) && pos < RP_W'(NUM_REGS)) begin
            rd_data_o = bk_q.regs[int'(pos)];
        end else begin
            rd_data_o = 8'hFF;
        end
    end

    assign regs_o = bk_q.regs;

    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bk_q.regs[CNT_IDX] != 8'h00); // R4

    AST_PLAIN_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bk_q.regs[0]) |-> $past(wr_stb_i)); // R2

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_chk
        AST_PAIR_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(bk_q.regs[PAIR_FIRST+2*p]) || !$stable(bk_q.regs[PAIR_FIRST+2*p+1]))
            |-> $past(stop_i)); // R5
    end
endmodule

// File: rtl/clkcfg_smbus_slave.sv
module clkcfg_smbus_slave
    import cfgs_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int         NUM_REGS    = 21,
    parameter int         SYNC_STAGES = 2,
    parameter int         CNT_IDX     = 8,
    parameter int         ID_IDX      = 7,
    parameter int         PAIR_FIRST  = 11,
    parameter int         NUM_PAIRS   = 2,
    parameter logic [3:0] REV         = 4'h1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_o,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    localparam int BC_W = $clog2(NUM_REGS + 3) + 1;
    localparam int RP_W = BYTE_W + 1;

    logic            scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic            wr_stb;
    logic [BC_W-1:0] wr_idx;
    byte_t           wr_data, rd_data;
    logic [RP_W-1:0] rd_ptr;

    cfgs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s_o   (scl_s),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (bus_start),
        .stop_o    (bus_stop)
    );

    cfgs_link #(.SLAVE_ADDR(SLAVE_ADDR), .BC_W(BC_W), .RP_W(RP_W)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s_i   (scl_s),
        .sda_s_i   (sda_s),
        .scl_rise_i(scl_rise),
        .scl_fall_i(scl_fall),
        .start_i   (bus_start),
        .stop_i    (bus_stop),
        .rd_data_i (rd_data),
        .sda_oe_o  (sda_oe),
        .rd_ptr_o  (rd_ptr),
        .wr_stb_o  (wr_stb),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    cfgs_regbank #(
        .NUM_REGS  (NUM_REGS),
        .BC_W      (BC_W),
        .RP_W      (RP_W),
        .CNT_IDX   (CNT_IDX),
        .ID_IDX    (ID_IDX),
        .PAIR_FIRST(PAIR_FIRST),
        .NUM_PAIRS (NUM_PAIRS),
        .REV       (REV)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr_stb),
        .wr_idx_i (wr_idx),
        .wr_data_i(wr_data),
        .start_i  (bus_start),
        .stop_i   (bus_stop),
        .rd_ptr_i (rd_ptr),
        .rd_data_o(rd_data),
        .regs_o   (cfg_o)
    );

    assign sda_o = 1'b0;
endmodule

// File: tb/tb_clkcfg_smbus_slave.sv
module tb_clkcfg_smbus_slave;
    localparam int         NREG  = 21;
    localparam logic [6:0] SADDR = 7'h69;
    localparam logic [3:0] REV   = 4'h5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_o, sda_oe, sda_bus;
    logic [NREG*8-1:0] cfg;

    assign sda_bus = m_sda & (sda_oe ? sda_o : 1'b1);

    always #10 clk = ~clk;

    clkcfg_smbus_slave #(.SLAVE_ADDR(SADDR), .NUM_REGS(NREG), .REV(REV)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_o(sda_o), .sda_oe(sda_oe), .cfg_o(cfg)
    );

    int n_chk = 0;
    int n_bad = 0;
    int oe_viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] exp_r [NREG];
    logic [7:0] wbuf [32];

    always @(negedge clk) begin
        if (sda_oe !== oe_prev && m_scl) oe_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic q_wait;
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; q_wait; m_scl = 1'b1; q_wait; m_sda = 1'b0; q_wait; m_scl = 1'b0; q_wait;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; q_wait; m_scl = 1'b1; q_wait; m_sda = 1'b1; q_wait; q_wait;
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            m_sda = b[i]; q_wait; m_scl = 1'b1; q_wait; q_wait; m_scl = 1'b0; q_wait;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; q_wait; m_scl = 1'b1; q_wait; acked = !sda_bus; q_wait; m_scl = 1'b0; q_wait;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] data);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q_wait; m_scl = 1'b1; q_wait; data[i] = sda_bus; q_wait; m_scl = 1'b0; q_wait;
        end
        m_sda = !ack_it; q_wait; m_scl = 1'b1; q_wait; q_wait; m_scl = 1'b0; q_wait;
        m_sda = 1'b1;
    endtask

    task automatic wr_block(input int n, output int nacks);
        logic a;
        nacks = 0;
        bus_start;
        send_byte({SADDR, 1'b0}, a); if (!a) nacks++;
        send_byte(8'hA5, a);         if (!a) nacks++;
        send_byte(8'h3C, a);         if (!a) nacks++;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); if (!a) nacks++;
        end
        bus_stop;
        q_wait;
    endtask

    task automatic model_wr(input int n);
        for (int i = 0; i < n && i < NREG; i++) begin
            if (i >= 11 && i <= 14) begin
                if (11 + ((i - 11) / 2) * 2 + 1 < n) exp_r[i] = wbuf[i];
            end else if (i == 8) begin
                if (wbuf[i] != 8'h00) exp_r[i] = wbuf[i];
            end else if (i != 7) begin
                exp_r[i] = wbuf[i];
            end
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, $sformatf("reg%0d", i), 32'(cfg[i*8 +: 8]), 32'(exp_r[i]));
    endtask

    task automatic t_reset;
        for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
        exp_r[8] = 8'h08;
        exp_r[7] = {4'b1001, REV};
        check_bank("R7");
        chk("R6", "id byte", 32'(cfg[7*8 +: 8]), 32'h95);
        chk("R4", "count reset", 32'(cfg[8*8 +: 8]), 32'h08);
        chk("R10", "oe at reset", 32'(sda_oe), 32'h0);
    endtask

    task automatic t_bad_addr;
        logic a;
        bus_start;
        send_byte({7'h22, 1'b0}, a);
        chk("R1", "foreign address ack", 32'(a), 32'h0);
        send_byte(8'h00, a);
        chk("R1", "byte after foreign address ack", 32'(a), 32'h0);
        bus_stop;
        q_wait;
        check_bank("R1");
    endtask

    task automatic t_short_write;
        int nk;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_block(3, nk);
        chk("R2", "nacks in short write", 32'(nk), 32'h0);
        model_wr(3);
        chk("R2", "reg0 holds first data byte", 32'(cfg[7:0]), 32'h11);
        check_bank("R3");
    endtask

    task automatic t_partial;
        logic a;
        bus_start;
        send_byte({SADDR, 1'b0}, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        send_byte(8'h77, a);
        send_bits(8'h5A, 4);
        m_scl = 1'b0; q_wait;
        bus_stop;
        q_wait;
        exp_r[0] = 8'h77;
        chk("R3", "reg1 after cut byte", 32'(cfg[15:8]), 32'h22);
        check_bank("R3");
    endtask

    task automatic t_full;
        int nk;
        for (int i = 0; i < 15; i++) wbuf[i] = 8'h40 + 8'(i);
        wbuf[7] = 8'hEE;
        wbuf[8] = 8'h00;
        wr_block(15, nk);
        model_wr(15);
        chk("R4", "count after zero write", 32'(cfg[8*8 +: 8]), 32'h08);
        chk("R6", "id after write", 32'(cfg[7*8 +: 8]), 32'h95);
        chk("R5", "pair A hi", 32'(cfg[12*8 +: 8]), 32'h4C);
        chk("R5", "pair B lo", 32'(cfg[13*8 +: 8]), 32'h4D);
        check_bank("R5");
    endtask

    task automatic t_half_pair;
        int nk;
        for (int i = 0; i < 15; i++) wbuf[i] = 8'hC0 + 8'(i);
        wr_block(12, nk);
        model_wr(12);
        chk("R5", "pair A lo alone kept", 32'(cfg[11*8 +: 8]), 32'h4B);
        check_bank("R5");
        for (int i = 0; i < 15; i++) wbuf[i] = 8'hD0 + 8'(i);
        wr_block(14, nk);
        model_wr(14);
        chk("R5", "pair A committed", 32'(cfg[11*8 +: 8]), 32'hDB);
        chk("R5", "pair B lo alone kept", 32'(cfg[13*8 +: 8]), 32'h4D);
        check_bank("R5");
    endtask

    task automatic t_cnt_write;
        int nk;
        for (int i = 0; i < 9; i++) wbuf[i] = 8'h60 + 8'(i);
        wbuf[8] = 8'h05;
        wr_block(9, nk);
        model_wr(9);
        chk("R4", "count accepts nonzero", 32'(cfg[8*8 +: 8]), 32'h05);
    endtask

    task automatic t_read;
        logic a;
        logic [7:0] d;
        logic [7:0] expect_rd [7];
        int nk;
        expect_rd[0] = exp_r[8];
        for (int i = 0; i < 5; i++) expect_rd[i+1] = exp_r[i];
        expect_rd[6] = 8'hFF;
        bus_start;
        send_byte({SADDR, 1'b1}, a);
        chk("R1", "read address ack", 32'(a), 32'h1);
        for (int i = 0; i < 7; i++) begin
            recv_byte(i < 6, d);
            chk("R8", $sformatf("read byte %0d", i), 32'(d), 32'(expect_rd[i]));
        end
        chk("R9", "oe after nack", 32'(sda_oe), 32'h0);
        q_wait;
        chk("R9", "sda released", 32'(sda_bus), 32'h1);
        bus_stop;
        q_wait;
        wbuf[0] = 8'h99;
        wr_block(1, nk);
        model_wr(1);
        chk("R9", "write after read nacks", 32'(nk), 32'h0);
        chk("R9", "write after read", 32'(cfg[7:0]), 32'h99);
    endtask

    task automatic t_overrun;
        int nk;
        for (int i = 0; i < 23; i++) wbuf[i] = 8'h80 + 8'(i);
        wr_block(23, nk);
        model_wr(23);
        chk("R11", "nacks in overrun", 32'(nk), 32'h0);
        chk("R11", "last register", 32'(cfg[20*8 +: 8]), 32'h94);
        check_bank("R11");
    endtask

    task automatic t_oe_rule;
        chk("R10", "oe changes with scl high", 32'(oe_viol), 32'h0);
        chk("R10", "sda_o level", 32'(sda_o), 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset;
        t_bad_addr;
        t_short_write;
        t_partial;
        t_full;
        t_half_pair;
        t_cnt_write;
        t_read;
        t_overrun;
        t_oe_rule;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule